// File: doc/BRIEF.md
# SPI Host Chip-Select Sequencer

This block owns the four chip-select lines of an SPI host. Software programs a 32-bit mode word through a write port, and that port ignores writes while a write-protect input is high. From that word the block picks which line or lines to assert. It then applies a polarity and keeps a minimum idle time between one select ending and the next one starting.

The serial shifter is not part of the block. It appears only as a busy output and a done input. A start request is taken when the block is idle, or when its idle-gap counter expires. It is only taken if the mode word allows it: host mode must be on, fixed peripheral select must be chosen, and, when the wait-for-read option is set, the receive register must be empty. A request that cannot be taken yet is remembered.

Two kinds of select pattern exist. One is a priority decode that picks the line at the lowest zero bit of the select field. The other passes the field straight through to an external 4-to-16 decoder. A select field of all ones in priority mode is illegal. It sets a sticky error flag, and no transfer is started.

Top module: `spi_cs_seq`

## Requirements
- R1: The mode word resets to zero and is readable on `modeOut`. A write is taken only when `wrEn` is high and `wpEn` is low; otherwise the stored word stays unchanged.
- R2: Bit 2 selects the decode style; when it is 0, the select field (bits 19:16) is decoded by its lowest zero bit into a low-active pattern. For example xxx0 gives 1110, xx01 gives 1101, x011 gives 1011 and 0111 gives 0111.
- R3: When bit 2 is 1, the active pattern equals the select field unchanged.
- R4: Bit 14 inverts every line. With bit 14 at 0 the idle level is 1111 and the lines are active low; with bit 14 at 1 the idle level is 0000 and the active pattern is inverted.
- R5: The select pattern appears on the clock edge that takes a start, and `xferBusy` rises one cycle later. `xferBusy` stays high until `xferDone` is seen. On the edge that samples `xferDone`, the lines return to idle and `xferBusy` falls.
- R6: After a select ends, the lines stay idle for G ticks before the next select begins. G is the value in bits 31:24, with a floor of 6.
- R7: When bit 3 is 0, every clock is a gap tick. When bit 3 is 1, only cycles with `altTick` high count.
- R8: When bit 5 is 1, no start is taken while `rxUnread` is high. The request is kept and is taken once `rxUnread` falls. When bit 5 is 0, `rxUnread` has no effect.
- R9: A start is taken only with bit 0 (host) at 1 and bit 1 (variable select) at 0; otherwise the request is kept.
- R10: A start request made while a transfer or a gap is in progress is kept. It launches at the first allowed point. Several such requests merge into one.
- R11: In priority-decode mode, a select field of 1111 makes a start attempt leave the lines idle. The attempt consumes the request and sets `pcsErr`. `pcsErr` stays set until an accepted mode write clears it.
- R12: The select pattern is captured when a start is taken. A mode write during a transfer does not change which lines are asserted until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Mode word write strobe |
| wpEn | input | 1 | Write protect; blocks mode writes while high |
| wrData | input | 32 | Mode word write data |
| altTick | input | 1 | Alternate gap tick enable |
| rxUnread | input | 1 | Receive register holds unread data |
| startReq | input | 1 | Request to begin a transfer |
| xferDone | input | 1 | Shifter reports end of transfer |
| xferBusy | output | 1 | Transfer in progress toward the shifter |
| csLines | output | 4 | Chip-select lines after polarity |
| pcsErr | output | 1 | Sticky illegal-select flag |
| modeOut | output | 32 | Current mode word |

## Verification
The hardest case to reach is a gap expiring in the same cycle that a remembered request is tested against the gating rules and the illegal-select check. To get there, the stimulus issues a second start while the shifter is still busy, so that the request is pending when the gap counter runs out. It then measures the exact number of idle cycles before the next select begins. This is repeated with a delay below the floor, with a delay above it, and with a sparse alternate tick, so that the gap ends at a cycle the clock alone would not predict.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_GAP    = 2'd3
  } phase_e;

  // control -> datapath
  typedef struct packed {
    logic loadSel;
    logic loadGap;
    logic csOn;
    logic setErr;
  } strobe_t;

  // datapath -> control
  typedef struct packed {
    logic gateOk;
    logic forbidden;
    logic gapDone;
  } status_t;

  // mode word field positions
  localparam int DLY_LSB   = 24;
  localparam int SEL_LSB   = 16;
  localparam int INV_BIT   = 14;
  localparam int WAITRX_BIT = 5;
  localparam int SRC_BIT   = 3;
  localparam int DEC_BIT   = 2;
  localparam int VAR_BIT   = 1;
  localparam int HOST_BIT  = 0;

endpackage

// File: rtl/spi_cs_datapath.sv
module spi_cs_datapath
  import spi_cs_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SEL_W   = 4,
  parameter int DLY_W   = 8,
  parameter int MIN_GAP = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wpEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              altTick,
  input  logic              rxUnread,
  input  strobe_t           strb,
  output status_t           stat,
  output logic [SEL_W-1:0]  csLines,
  output logic              errFlag,
  output logic [DATA_W-1:0] modeOut
);

  localparam logic [DLY_W-1:0] GAP_FLOOR = DLY_W'(MIN_GAP);
  localparam logic [DLY_W-1:0] CNT_ONE   = DLY_W'(1);

  logic [DATA_W-1:0] modeReg;
  logic              wrAccept;

  assign wrAccept = wrEn & ~wpEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         modeReg <= '0;
    else if (wrAccept) modeReg <= wrData;
  end

  assign modeOut = modeReg;

  // field views
  logic [DLY_W-1:0] dlyField;
  logic [SEL_W-1:0] selField;
  logic csInv, waitRx, srcAlt, decBypass, varSel, hostMode;

  assign dlyField  = modeReg[DLY_LSB +: DLY_W];
  assign selField  = modeReg[SEL_LSB +: SEL_W];
  assign csInv     = modeReg[INV_BIT];
  assign waitRx    = modeReg[WAITRX_BIT];
  assign srcAlt    = modeReg[SRC_BIT];
  assign decBypass = modeReg[DEC_BIT];
  assign varSel    = modeReg[VAR_BIT];
  assign hostMode  = modeReg[HOST_BIT];

  // gap counter
  logic [DLY_W-1:0] gapLen, gapCnt;
  logic             tick;

  assign gapLen = (dlyField <= GAP_FLOOR) ? GAP_FLOOR : dlyField;
  assign tick   = srcAlt ? altTick : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      gapCnt <= '0;
    else if (strb.loadGap)          gapCnt <= gapLen;
    else if (tick && gapCnt != '0)  gapCnt <= gapCnt - CNT_ONE;
  end

  assign stat.gapDone = tick && (gapCnt == CNT_ONE);

  // select decode: lowest zero bit wins
  logic [SEL_W-1:0] lowPat, nextSel;
  logic             hit;

  always_comb begin
    lowPat = '1;
    hit    = 1'b0;
    for (int i = 0; i < SEL_W; i++) begin
      if (!hit && !selField[i]) begin
        lowPat[i] = 1'b0;
        hit       = 1'b1;
      end
    end
  end

  assign nextSel        = decBypass ? selField : lowPat;
  assign stat.forbidden = !decBypass && (&selField);
  assign stat.gateOk    = hostMode && !varSel && !(waitRx && rxUnread);

  logic [SEL_W-1:0] selReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             selReg <= '1;
    else if (strb.loadSel) selReg <= nextSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            errFlag <= 1'b0;
    else if (strb.setErr) errFlag <= 1'b1;
    else if (wrAccept)    errFlag <= 1'b0;
  end

  // per-line drive with polarity
  for (genvar g = 0; g < SEL_W; g++) begin : g_line
    assign csLines[g] = (strb.csOn ? selReg[g] : 1'b1) ^ csInv;
  end

  // R1
  write_protect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wpEn) |=> $stable(modeReg));

  // R6
  gap_respected_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadSel |-> (gapCnt <= CNT_ONE));

  // R8
  wait_rx_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadSel |-> !(waitRx && rxUnread));

  // R11
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(stat.forbidden));

endmodule

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl
  import spi_cs_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    xferDone,
  input  status_t stat,
  output strobe_t strb,
  output logic    busyO
);

  phase_e phase, nextPhase;
  logic   pending, pendNext;
  logic   req, launchPt, attempt, goRun;

  always_comb begin
    req      = pending | startReq;
    launchPt = (phase == PH_IDLE) || (phase == PH_GAP && stat.gapDone);
    attempt  = launchPt && req && stat.gateOk;
    goRun    = attempt && !stat.forbidden;
    pendNext = attempt ? 1'b0 : req;

    nextPhase = phase;
    unique case (phase)
      PH_IDLE:   if (goRun) nextPhase = PH_SETUP;
      PH_SETUP:  nextPhase = PH_ACTIVE;
      PH_ACTIVE: if (xferDone) nextPhase = PH_GAP;
      PH_GAP:    if (stat.gapDone) nextPhase = goRun ? PH_SETUP : PH_IDLE;
      default:   nextPhase = PH_IDLE;
    endcase

    strb.loadSel = goRun;
    strb.setErr  = attempt && stat.forbidden;
    strb.loadGap = (phase == PH_ACTIVE) && xferDone;
    strb.csOn    = (phase == PH_SETUP) || (phase == PH_ACTIVE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      pending <= 1'b0;
    end else begin
      phase   <= nextPhase;
      pending <= pendNext;
    end
  end

  assign busyO = (phase == PH_ACTIVE);

  // R5
  busy_after_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyO) |-> $past(phase) == PH_SETUP);

  // R5
  release_on_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyO && xferDone) |=> (!busyO && phase == PH_GAP));

  // R10
  request_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !attempt) |=> pending);

endmodule

// File: rtl/spi_cs_seq.sv
module spi_cs_seq
  import spi_cs_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SEL_W   = 4,
  parameter int DLY_W   = 8,
  parameter int MIN_GAP = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wpEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              altTick,
  input  logic              rxUnread,
  input  logic              startReq,
  input  logic              xferDone,
  output logic              xferBusy,
  output logic [SEL_W-1:0]  csLines,
  output logic              pcsErr,
  output logic [DATA_W-1:0] modeOut
);

  strobe_t strb;
  status_t stat;

  spi_cs_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .xferDone (xferDone),
    .stat     (stat),
    .strb     (strb),
    .busyO    (xferBusy)
  );

  spi_cs_datapath #(
    .DATA_W  (DATA_W),
    .SEL_W   (SEL_W),
    .DLY_W   (DLY_W),
    .MIN_GAP (MIN_GAP)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wpEn     (wpEn),
    .wrData   (wrData),
    .altTick  (altTick),
    .rxUnread (rxUnread),
    .strb     (strb),
    .stat     (stat),
    .csLines  (csLines),
    .errFlag  (pcsErr),
    .modeOut  (modeOut)
  );

endmodule

// File: tb/spi_cs_seq_test.sv
module spi_cs_seq_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0, wpEn = 1'b0, altTick = 1'b0, rxUnread = 1'b0;
  logic startReq = 1'b0, xferDone = 1'b0;
  logic [31:0] wrData = '0;
  logic        xferBusy, pcsErr;
  logic [3:0]  csLines;
  logic [31:0] modeOut;

  spi_cs_seq uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wpEn(wpEn), .wrData(wrData),
    .altTick(altTick), .rxUnread(rxUnread), .startReq(startReq),
    .xferDone(xferDone), .xferBusy(xferBusy), .csLines(csLines),
    .pcsErr(pcsErr), .modeOut(modeOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0, failures = 0, cyc = 0;
  string curReq = "R1";

  // reference model state
  logic [31:0] mMode = '0;
  logic [3:0]  mSel = 4'hF;
  logic        mErr = 1'b0, mPend = 1'b0;
  int          mPhase = 0, mGap = 0;   // 0 idle, 1 select, 2 busy, 3 gap

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [3:0] refPattern(logic [31:0] m);
    if (m[2]) return m[19:16];
    for (int i = 0; i < 4; i++)
      if (!m[16+i]) return ~(4'b0001 << i);
    return 4'hF;
  endfunction

  function automatic int refGap(logic [31:0] m);
    return (m[31:24] <= 8'd6) ? 6 : int'(m[31:24]);
  endfunction

  task automatic modelStep();
    logic tick, gate, forb, req, launchPt, attempt, wrAcc;
    tick     = mMode[3] ? altTick : 1'b1;
    gate     = mMode[0] && !mMode[1] && !(mMode[5] && rxUnread);
    forb     = !mMode[2] && (mMode[19:16] == 4'hF);
    req      = mPend || startReq;
    launchPt = (mPhase == 0) || (mPhase == 3 && tick && mGap == 1);
    attempt  = launchPt && req && gate;
    wrAcc    = wrEn && !wpEn;
    case (mPhase)
      0: if (attempt && !forb) begin mPhase = 1; mSel = refPattern(mMode); end
      1: mPhase = 2;
      2: if (xferDone) begin mPhase = 3; mGap = refGap(mMode); end
      default: if (tick) begin
        if (mGap == 1) begin
          if (attempt && !forb) begin mPhase = 1; mSel = refPattern(mMode); end
          else mPhase = 0;
        end
        mGap--;
      end
    endcase
    if (attempt && forb) mErr = 1'b1;
    else if (wrAcc)      mErr = 1'b0;
    mPend = attempt ? 1'b0 : req;
    if (wrAcc) mMode = wrData;
  endtask

  task automatic cycle();
    logic [3:0] expCs;
    @(posedge clk);
    if (!rstN) begin
      mMode = '0; mSel = 4'hF; mErr = 1'b0; mPend = 1'b0; mPhase = 0; mGap = 0;
    end else begin
      modelStep();
    end
    @(negedge clk);
    expCs = ((mPhase == 1 || mPhase == 2) ? mSel : 4'hF) ^ {4{mMode[14]}};
    check(curReq, "model csLines", 32'(csLines), 32'(expCs));
    check(curReq, "model xferBusy", 32'(xferBusy), 32'(mPhase == 2));
    check(curReq, "model pcsErr", 32'(pcsErr), 32'(mErr));
    check(curReq, "model modeOut", modeOut, mMode);
    cyc++;
    altTick = (cyc % 3 == 0);
  endtask

  task automatic writeMode(logic [31:0] v, logic prot);
    wrData = v; wrEn = 1'b1; wpEn = prot;
    cycle();
    wrEn = 1'b0; wpEn = 1'b0;
  endtask

  task automatic pulseStart();
    startReq = 1'b1;
    cycle();
    startReq = 1'b0;
  endtask

  task automatic waitBusy();
    for (int w = 0; w < 300 && !xferBusy; w++) cycle();
  endtask

  task automatic finishXfer(int n);
    repeat (n) cycle();
    xferDone = 1'b1;
    cycle();
    xferDone = 1'b0;
  endtask

  task automatic countGap(logic [3:0] idleLvl, output int k);
    k = 0;
    while (csLines == idleLvl && k < 500) begin k++; cycle(); end
  endtask

  function automatic logic [31:0] hostSel(logic [3:0] pcs);
    return 32'h1 | (32'(pcs) << 16);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int k;
    logic [3:0] pcsList [6] = '{4'h0, 4'h5, 4'h3, 4'h7, 4'hA, 4'hB};
    logic [3:0] patList [6] = '{4'hE, 4'hD, 4'hB, 4'h7, 4'hE, 4'hB};

    repeat (3) cycle();
    rstN = 1'b1;
    // R1 / R4: reset state
    check("R1", "reset modeOut", modeOut, 32'h0);
    check("R4", "reset idle level", 32'(csLines), 32'hF);
    check("R5", "reset busy", 32'(xferBusy), 32'h0);
    check("R11", "reset err", 32'(pcsErr), 32'h0);

    curReq = "R1";
    writeMode(32'h0000_0001, 1'b1);
    check("R1", "protected write ignored", modeOut, 32'h0);

    // R9: not host, then variable select
    curReq = "R9";
    pulseStart();
    repeat (5) cycle();
    check("R9", "no start in client mode", 32'(csLines), 32'hF);
    writeMode(32'h0000_0003, 1'b0);
    repeat (3) cycle();
    check("R9", "no start with variable select", 32'(csLines), 32'hF);
    writeMode(hostSel(4'hE), 1'b0);
    cycle();
    check("R9", "kept request launches", 32'(csLines), 32'hE);
    finishXfer(2);

    // R2 priority decode
    curReq = "R2";
    for (int i = 0; i < 6; i++) begin
      writeMode(hostSel(pcsList[i]), 1'b0);
      pulseStart();
      waitBusy();
      check("R2", "decoded pattern", 32'(csLines), 32'(patList[i]));
      finishXfer(1);
    end

    // R3 bypass
    curReq = "R3";
    writeMode(hostSel(4'h9) | 32'h4, 1'b0);
    pulseStart(); waitBusy();
    check("R3", "bypass pattern 9", 32'(csLines), 32'h9);
    finishXfer(1);
    writeMode(hostSel(4'h6) | 32'h4, 1'b0);
    pulseStart(); waitBusy();
    check("R3", "bypass pattern 6", 32'(csLines), 32'h6);
    finishXfer(1);

    // R4 polarity
    curReq = "R4";
    writeMode(hostSel(4'h7) | 32'h4000, 1'b0);
    repeat (10) cycle();
    check("R4", "inverted idle level", 32'(csLines), 32'h0);
    pulseStart(); waitBusy();
    check("R4", "inverted active pattern", 32'(csLines), 32'h8);
    finishXfer(1);

    // R5 handshake timing
    curReq = "R5";
    writeMode(hostSel(4'h0), 1'b0);
    repeat (10) cycle();
    startReq = 1'b1; cycle(); startReq = 1'b0;
    check("R5", "select before busy cs", 32'(csLines), 32'hE);
    check("R5", "select before busy busy", 32'(xferBusy), 32'h0);
    cycle();
    check("R5", "busy follows", 32'(xferBusy), 32'h1);
    cycle();
    xferDone = 1'b1; cycle(); xferDone = 1'b0;
    check("R5", "busy drops on done", 32'(xferBusy), 32'h0);
    check("R5", "lines idle on done", 32'(csLines), 32'hF);

    // R6 / R10 gap floor and long gap with pending request
    curReq = "R6";
    writeMode(32'h0300_0001, 1'b0);
    repeat (10) cycle();
    pulseStart(); waitBusy();
    pulseStart(); pulseStart();             // R10: merged pending requests
    finishXfer(2);
    countGap(4'hF, k);
    check("R6", "gap floor of six", 32'(k), 32'd6);
    check("R10", "pending request launched", 32'(csLines), 32'hE);
    waitBusy(); finishXfer(1);
    repeat (3) cycle();
    check("R10", "merged requests give one transfer", 32'(csLines), 32'hF);

    writeMode(32'h0A00_0001, 1'b0);
    repeat (12) cycle();
    pulseStart(); waitBusy(); pulseStart();
    finishXfer(1);
    countGap(4'hF, k);
    check("R6", "gap of ten", 32'(k), 32'd10);
    waitBusy(); finishXfer(1);

    // R7 alternate tick source
    curReq = "R7";
    writeMode(32'h0600_0009, 1'b0);
    repeat (40) cycle();
    pulseStart(); waitBusy(); pulseStart();
    finishXfer(1);
    countGap(4'hF, k);
    check("R7", "sparse ticks stretch gap", 32'(k >= 16), 32'h1);
    waitBusy(); finishXfer(1);

    // R8 wait for receive read
    curReq = "R8";
    writeMode(32'h0000_0021, 1'b0);
    repeat (40) cycle();
    rxUnread = 1'b1;
    pulseStart();
    repeat (6) cycle();
    check("R8", "blocked while unread", 32'(csLines), 32'hF);
    rxUnread = 1'b0;
    cycle();
    check("R8", "launch after read", 32'(csLines), 32'hE);
    finishXfer(1);
    writeMode(32'h0000_0001, 1'b0);
    repeat (10) cycle();
    rxUnread = 1'b1;
    pulseStart();
    check("R8", "no wait when option off", 32'(csLines), 32'hE);
    rxUnread = 1'b0;
    finishXfer(1);

    // R11 forbidden select
    curReq = "R11";
    writeMode(hostSel(4'hF), 1'b0);
    repeat (10) cycle();
    pulseStart();
    check("R11", "forbidden leaves idle", 32'(csLines), 32'hF);
    check("R11", "error set", 32'(pcsErr), 32'h1);
    writeMode(hostSel(4'h0), 1'b1);
    check("R11", "protected write keeps error", 32'(pcsErr), 32'h1);
    writeMode(hostSel(4'h0), 1'b0);
    repeat (3) cycle();
    check("R11", "accepted write clears error", 32'(pcsErr), 32'h0);
    check("R11", "request consumed", 32'(csLines), 32'hF);

    // R12 pattern captured at start
    curReq = "R12";
    pulseStart(); waitBusy();
    writeMode(hostSel(4'h7), 1'b0);
    check("R12", "pattern held mid-transfer", 32'(csLines), 32'hE);
    finishXfer(1);
    repeat (8) cycle();
    pulseStart(); waitBusy();
    check("R12", "new pattern next transfer", 32'(csLines), 32'h7);
    finishXfer(1);
    repeat (8) cycle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule